// File: doc/BRIEF.md
# Audio FIFO status and interrupt unit

This block sits between a processor-side register port and a serial audio link. It holds two 16-word queues of 32-bit stereo samples: a transmit queue that software fills and the link drains, and a receive queue that the link fills and software drains. Both queues share one data address. A read there pops the receive queue and a write there pushes the transmit queue.

From the queue levels and two programmable thresholds the block raises service requests. They drive the DMA request outputs directly. Through a mask they also feed a single interrupt line. Sticky error flags record a receive push into a full queue and a transmit pop from an empty queue. Software clears these flags by writing ones to a separate clear address. A soft-reset bit in the control word empties both queues and returns every register to its reset value. Software pulses this bit whenever it toggles the link enable during operation.

The serial shifter and the bus decoder are outside the block. The link side is a pop strobe with head data for transmit, a push strobe with data for receive, and a busy input.

Top module: `aud_fifo_irq`

Register map (3-bit address):

| Address | Register | Access |
|---------|----------|--------|
| 0 | control | read/write |
| 1 | status | read-only |
| 2 | mask | read/write |
| 3 | clear | write-only |
| 4 | data | read pops receive, write pushes transmit |

Any other address reads zero.

## Requirements
- R1: After reset, control and mask read 0, status reads 0x99, the interrupt is low and both DMA requests are high.
- R2: Control (address 0) keeps the receive threshold in bits 15:12, the transmit threshold in bits 11:8 and the link enable in bit 0; all other bits read 0 and bit 0 drives linkEnable. Unmapped addresses read 0.
- R3: A write to address 4 appends to the transmit queue (depth 16). A write to a full queue is dropped. txData shows the oldest entry and txPop removes it in arrival order.
- R4: rxPush appends rxData to the receive queue. A read of address 4 returns the oldest entry combinationally and removes it at the clock edge. A read of the empty queue returns 0 and changes nothing.
- R5: Status bit 4 and rxDmaReq are 1 exactly when the receive level is at or above the receive threshold.
- R6: Status bit 3 and txDmaReq are 1 exactly when the transmit level is at or below the transmit threshold.
- R7: An rxPush into a full receive queue drops the word and sets status bit 6, which stays set until a write to the clear register (address 3) with bit 6 set. A new overrun in the same cycle as the clear wins.
- R8: A txPop on an empty transmit queue shows txData 0 and sets status bit 5, which stays set until a clear write with bit 5 set.
- R9: Mask (address 2) stores bits 6:3 only. irq is the OR of status bits 6:3 each ANDed with the same mask bit.
- R10: A control write with bit 3 set empties both queues, clears both error flags and loads 0 into control and mask, ignoring the rest of that write.
- R11: Status bit 2 follows linkBusy. Bit 7 is 1 when the link enable is clear and linkBusy is low. Bit 1 is receive-not-empty and bit 0 is transmit-not-full. Writes to status are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe (pops on data address) |
| regAddr | input | 3 | Register address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, combinational from current state |
| txPop | input | 1 | Link takes one transmit word |
| txData | output | 32 | Oldest transmit word, 0 when empty |
| rxPush | input | 1 | Link delivers one receive word |
| rxData | input | 32 | Receive word from the link |
| linkBusy | input | 1 | Link still shifting |
| linkEnable | output | 1 | Link enable from control bit 0 |
| irq | output | 1 | Masked status interrupt |
| txDmaReq | output | 1 | Transmit service request |
| rxDmaReq | output | 1 | Receive service request |

## Verification
The assertions assume that regWe and regRe are never high in the same cycle. They also assume that every strobe and address is a clean level during reset, because the level and drop properties reason about one event per port per cycle. The stimulus drives at most one register access per cycle. It raises each strobe at a falling edge and drops it just after the next rising edge, so each access or link event counts exactly once. The overflow and underflow checks deliberately hold the opposing link strobe low so that a queue at its limit is not drained in the same cycle.

// File: rtl/aud_fifo_pkg.sv
package aud_fifo_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;
  localparam int TH_W   = 4;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_MASK = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_CLR  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_DATA = 3'd4;

  // strobes from control to datapath
  typedef struct packed {
    logic txPush;
    logic rxPop;
    logic flush;
  } pathStrb_t;
endpackage

// File: rtl/aud_fifo_buf.sv
module aud_fifo_buf #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic [LW-1:0]    level
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic doPush, doPop, isFull, isEmpty;

  assign isFull  = (level == LW'(DEPTH));
  assign isEmpty = (level == '0);
  assign doPush  = push & ~isFull;
  assign doPop   = pop & ~isEmpty;
  assign headData = isEmpty ? '0 : mem[rdPtr];

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (doPush && !flush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/aud_fifo_path.sv
module aud_fifo_path
  import aud_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  pathStrb_t         strb,
  input  logic [DATA_W-1:0] txWord,
  input  logic              txPop,
  output logic [DATA_W-1:0] txHead,
  input  logic              rxPush,
  input  logic [DATA_W-1:0] rxWord,
  output logic [DATA_W-1:0] rxHead,
  output logic [LW-1:0]     txLevel,
  output logic [LW-1:0]     rxLevel
);
  aud_fifo_buf #(.WIDTH(DATA_W), .DEPTH(DEPTH)) txBuf (
    .clk(clk), .rstN(rstN), .flush(strb.flush),
    .push(strb.txPush), .pushData(txWord),
    .pop(txPop), .headData(txHead), .level(txLevel)
  );

  aud_fifo_buf #(.WIDTH(DATA_W), .DEPTH(DEPTH)) rxBuf (
    .clk(clk), .rstN(rstN), .flush(strb.flush),
    .push(rxPush), .pushData(rxWord),
    .pop(strb.rxPop), .headData(rxHead), .level(rxLevel)
  );
endmodule

// File: rtl/aud_fifo_ctrl.sv
module aud_fifo_ctrl
  import aud_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic              regRe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              txPop,
  input  logic              rxPush,
  input  logic              linkBusy,
  input  logic [LW-1:0]     txLevel,
  input  logic [LW-1:0]     rxLevel,
  input  logic [DATA_W-1:0] rxHead,
  output pathStrb_t         strb,
  output logic              linkEnable,
  output logic              irq,
  output logic              txDmaReq,
  output logic              rxDmaReq
);
  logic            enReg;
  logic [TH_W-1:0] rxTh, txTh;
  logic [3:0]      maskReg;   // mask bits 6:3
  logic            rorFlag, turFlag;
  logic            wrCtrl, wrMask, wrClr, softRst;
  logic            rxSvc, txSvc;
  logic [7:0]      statusBits;

  assign wrCtrl  = regWe && (regAddr == ADR_CTRL);
  assign wrMask  = regWe && (regAddr == ADR_MASK);
  assign wrClr   = regWe && (regAddr == ADR_CLR);
  assign softRst = wrCtrl && regWdata[3];

  assign strb.txPush = regWe && (regAddr == ADR_DATA);
  assign strb.rxPop  = regRe && (regAddr == ADR_DATA);
  assign strb.flush  = softRst;

  assign rxSvc = 32'(rxLevel) >= 32'(rxTh);
  assign txSvc = 32'(txLevel) <= 32'(txTh);

  assign statusBits = {~enReg & ~linkBusy, rorFlag, turFlag, rxSvc, txSvc,
                       linkBusy, rxLevel != '0, txLevel != LW'(DEPTH)};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg <= 1'b0; rxTh <= '0; txTh <= '0; maskReg <= '0;
      rorFlag <= 1'b0; turFlag <= 1'b0;
    end else if (softRst) begin
      enReg <= 1'b0; rxTh <= '0; txTh <= '0; maskReg <= '0;
      rorFlag <= 1'b0; turFlag <= 1'b0;
    end else begin
      if (wrCtrl) begin
        enReg <= regWdata[0];
        txTh  <= regWdata[11:8];
        rxTh  <= regWdata[15:12];
      end
      if (wrMask) maskReg <= regWdata[6:3];
      if (rxPush && rxLevel == LW'(DEPTH)) rorFlag <= 1'b1;
      else if (wrClr && regWdata[6])       rorFlag <= 1'b0;
      if (txPop && txLevel == '0)          turFlag <= 1'b1;
      else if (wrClr && regWdata[5])       turFlag <= 1'b0;
    end
  end

  always_comb begin
    regRdata = '0;
    if (regRe) begin
      case (regAddr)
        ADR_CTRL: regRdata = {16'h0, rxTh, txTh, 7'h0, enReg};
        ADR_STAT: regRdata = {24'h0, statusBits};
        ADR_MASK: regRdata = {25'h0, maskReg, 3'h0};
        ADR_DATA: regRdata = rxHead;
        default:  regRdata = '0;
      endcase
    end
  end

  assign linkEnable = enReg;
  assign irq        = |(statusBits[6:3] & maskReg);
  assign txDmaReq   = txSvc;
  assign rxDmaReq   = rxSvc;
endmodule

// File: rtl/aud_fifo_irq.sv
module aud_fifo_irq
  import aud_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic              regRe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              txPop,
  output logic [DATA_W-1:0] txData,
  input  logic              rxPush,
  input  logic [DATA_W-1:0] rxData,
  input  logic              linkBusy,
  output logic              linkEnable,
  output logic              irq,
  output logic              txDmaReq,
  output logic              rxDmaReq
);
  pathStrb_t         strb;
  logic [LW-1:0]     txLevel, rxLevel;
  logic [DATA_W-1:0] rxHead;

  aud_fifo_ctrl #(.DEPTH(DEPTH)) ctrlU (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .txPop(txPop), .rxPush(rxPush), .linkBusy(linkBusy),
    .txLevel(txLevel), .rxLevel(rxLevel), .rxHead(rxHead),
    .strb(strb), .linkEnable(linkEnable), .irq(irq),
    .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq)
  );

  aud_fifo_path #(.DEPTH(DEPTH)) pathU (
    .clk(clk), .rstN(rstN), .strb(strb),
    .txWord(regWdata), .txPop(txPop), .txHead(txData),
    .rxPush(rxPush), .rxWord(rxData), .rxHead(rxHead),
    .txLevel(txLevel), .rxLevel(rxLevel)
  );
endmodule

// File: rtl/aud_fifo_irq_chk.sv
module aud_fifo_irq_chk
  import aud_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic              regRe,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWdata,
  input logic              txPop,
  input logic              rxPush,
  input logic              linkEnable,
  input logic [LW-1:0]     txLevel,
  input logic [LW-1:0]     rxLevel
);
  logic dataWr, dataRd, rstWr;
  assign dataWr = regWe && regAddr == ADR_DATA;
  assign dataRd = regRe && regAddr == ADR_DATA;
  assign rstWr  = regWe && regAddr == ADR_CTRL && regWdata[3];

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (32'(txLevel) <= DEPTH) && (32'(rxLevel) <= DEPTH)); // R3

  AST_TX_FULL_DROP: assert property (@(posedge clk) disable iff (!rstN)
    dataWr && !txPop && !rstWr && txLevel == LW'(DEPTH) |=> txLevel == LW'(DEPTH)); // R3

  AST_RX_EMPTY_READ: assert property (@(posedge clk) disable iff (!rstN)
    dataRd && !rxPush && rxLevel == '0 |=> rxLevel == '0); // R4

  AST_RX_FULL_DROP: assert property (@(posedge clk) disable iff (!rstN)
    rxPush && !dataRd && !rstWr && rxLevel == LW'(DEPTH) |=> rxLevel == LW'(DEPTH)); // R7

  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rstN)
    rstWr |=> rxLevel == '0 && txLevel == '0 && !linkEnable); // R10
endmodule

bind aud_fifo_irq aud_fifo_irq_chk #(.DEPTH(DEPTH)) chkU (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
  .regWdata(regWdata), .txPop(txPop), .rxPush(rxPush),
  .linkEnable(linkEnable), .txLevel(txLevel), .rxLevel(rxLevel)
);

// File: tb/aud_fifo_irq_test.sv
module aud_fifo_irq_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0, regRe = 1'b0;
  logic [2:0] regAddr = '0;
  logic [31:0] regWdata = '0, rxData = '0;
  logic txPop = 1'b0, rxPush = 1'b0, linkBusy = 1'b0;
  logic [31:0] regRdata, txData;
  logic linkEnable, irq, txDmaReq, rxDmaReq;

  int checks = 0, errors = 0;
  logic [31:0] got;

  always #5 clk = ~clk;

  aud_fifo_irq uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .txPop(txPop), .txData(txData),
    .rxPush(rxPush), .rxData(rxData), .linkBusy(linkBusy),
    .linkEnable(linkEnable), .irq(irq), .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq)
  );

  localparam logic [2:0] OP_WR = 0, OP_RD = 1, OP_RXP = 2, OP_TXP = 3, OP_IRQ = 4;

  typedef struct packed {
    logic [2:0]  op;
    logic [2:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VECS [NV] = '{
    '{OP_RD,  3'd1, 32'h0,        32'h99,       8'd1},  // R1 status
    '{OP_RD,  3'd0, 32'h0,        32'h0,        8'd1},  // R1 control
    '{OP_IRQ, 3'd0, 32'h0,        32'h0,        8'd1},  // R1 irq
    '{OP_WR,  3'd0, 32'h0000E1F5, 32'h0,        8'd2},  // R2 write control
    '{OP_RD,  3'd0, 32'h0,        32'h0000E101, 8'd2},  // R2 readback
    '{OP_RD,  3'd1, 32'h0,        32'h09,       8'd11}, // R11 off clears
    '{OP_WR,  3'd4, 32'h11111111, 32'h0,        8'd3},  // R3
    '{OP_WR,  3'd4, 32'h22222222, 32'h0,        8'd3},  // R3
    '{OP_RD,  3'd1, 32'h0,        32'h01,       8'd6},  // R6 level 2 > 1
    '{OP_TXP, 3'd0, 32'h0,        32'h11111111, 8'd3},  // R3 order
    '{OP_RD,  3'd1, 32'h0,        32'h09,       8'd6},  // R6 level 1
    '{OP_TXP, 3'd0, 32'h0,        32'h22222222, 8'd3},  // R3
    '{OP_TXP, 3'd0, 32'h0,        32'h0,        8'd8},  // R8 empty pop
    '{OP_RD,  3'd1, 32'h0,        32'h29,       8'd8},  // R8 underrun flag
    '{OP_WR,  3'd2, 32'hFFFFFFFF, 32'h0,        8'd9},  // R9
    '{OP_RD,  3'd2, 32'h0,        32'h78,       8'd9},  // R9 mask bits
    '{OP_IRQ, 3'd0, 32'h0,        32'h1,        8'd9},  // R9
    '{OP_WR,  3'd3, 32'h20,       32'h0,        8'd8},  // R8 clear
    '{OP_RD,  3'd1, 32'h0,        32'h09,       8'd8},  // R8
    '{OP_WR,  3'd2, 32'h20,       32'h0,        8'd9},  // R9
    '{OP_IRQ, 3'd0, 32'h0,        32'h0,        8'd9},  // R9 masked off
    '{OP_RXP, 3'd0, 32'hA5A50001, 32'h0,        8'd4},  // R4
    '{OP_RXP, 3'd0, 32'hA5A50002, 32'h0,        8'd4},  // R4
    '{OP_RD,  3'd1, 32'h0,        32'h0B,       8'd11}, // R11 not empty
    '{OP_RD,  3'd4, 32'h0,        32'hA5A50001, 8'd4},  // R4
    '{OP_RD,  3'd4, 32'h0,        32'hA5A50002, 8'd4},  // R4
    '{OP_RD,  3'd4, 32'h0,        32'h0,        8'd4},  // R4 empty read
    '{OP_RD,  3'd1, 32'h0,        32'h09,       8'd4},  // R4
    '{OP_WR,  3'd1, 32'hFFFFFFFF, 32'h0,        8'd11}, // R11 status write
    '{OP_RD,  3'd1, 32'h0,        32'h09,       8'd11}, // R11 ignored
    '{OP_RD,  3'd5, 32'h0,        32'h0,        8'd2}   // R2 unmapped
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk); #1;
    regWe = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regRe = 1'b1; regAddr = a;
    #1 d = regRdata;
    @(posedge clk); #1;
    regRe = 1'b0;
  endtask

  task automatic linkRx(input logic [31:0] d);
    @(negedge clk);
    rxPush = 1'b1; rxData = d;
    @(posedge clk); #1;
    rxPush = 1'b0;
  endtask

  task automatic linkTx(output logic [31:0] d);
    @(negedge clk);
    txPop = 1'b1;
    #1 d = txData;
    @(posedge clk); #1;
    txPop = 1'b0;
  endtask

  task automatic finishRun;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    check("R1 txDmaReq", {31'h0, txDmaReq}, 32'h1);
    check("R1 rxDmaReq", {31'h0, rxDmaReq}, 32'h1);

    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        OP_WR:  wrReg(VECS[i].addr, VECS[i].data);
        OP_RXP: linkRx(VECS[i].data);
        OP_RD: begin
          rdReg(VECS[i].addr, got);
          check($sformatf("R%0d vec %0d", VECS[i].req, i), got, VECS[i].exp);
        end
        OP_TXP: begin
          linkTx(got);
          check($sformatf("R%0d vec %0d", VECS[i].req, i), got, VECS[i].exp);
        end
        default: begin
          @(negedge clk); #1;
          check($sformatf("R%0d vec %0d", VECS[i].req, i), {31'h0, irq}, VECS[i].exp);
        end
      endcase
    end
    check("R2 linkEnable", {31'h0, linkEnable}, 32'h1);

    // R5 receive threshold 14, fill to full, then overrun R7
    for (int i = 0; i < 16; i++) begin
      linkRx(32'hB0000000 + i);
      rdReg(3'd1, got);
      check("R5 rx service bit", {31'h0, got[4]}, {31'h0, (i + 1) >= 14});
      check("R5 rxDmaReq", {31'h0, rxDmaReq}, {31'h0, (i + 1) >= 14});
    end
    rdReg(3'd1, got);
    check("R7 no overrun yet", {31'h0, got[6]}, 32'h0);
    linkRx(32'hDEADBEEF);
    rdReg(3'd1, got);
    check("R7 overrun set", {31'h0, got[6]}, 32'h1);
    for (int i = 0; i < 16; i++) begin
      rdReg(3'd4, got);
      check("R7 rx order, dropped word absent", got, 32'hB0000000 + i);
    end
    rdReg(3'd4, got);
    check("R4 empty after drain", got, 32'h0);
    rdReg(3'd1, got);
    check("R7 overrun sticky", {31'h0, got[6]}, 32'h1);
    wrReg(3'd3, 32'h20);
    rdReg(3'd1, got);
    check("R7 bit5 clear leaves overrun", {31'h0, got[6]}, 32'h1);
    wrReg(3'd3, 32'h40);
    rdReg(3'd1, got);
    check("R7 overrun cleared", {31'h0, got[6]}, 32'h0);

    // R3 transmit fill, full drop
    for (int i = 0; i < 16; i++) begin
      wrReg(3'd4, 32'hC0000000 + i);
      rdReg(3'd1, got);
      check("R11 tx not full bit", {31'h0, got[0]}, {31'h0, (i + 1) < 16});
    end
    check("R6 txDmaReq full", {31'h0, txDmaReq}, 32'h0);
    wrReg(3'd4, 32'hDEADBEEF);
    for (int i = 0; i < 16; i++) begin
      linkTx(got);
      check("R3 tx order, full write dropped", got, 32'hC0000000 + i);
    end
    linkTx(got);
    check("R3 tx empty head", got, 32'h0);
    rdReg(3'd1, got);
    check("R8 underrun after drain", {31'h0, got[5]}, 32'h1);
    wrReg(3'd3, 32'h60);

    // R11 busy and controller off
    wrReg(3'd0, 32'h0);
    @(negedge clk); linkBusy = 1'b1;
    rdReg(3'd1, got);
    check("R11 busy off-bit", got[7:0], 8'h1D);
    @(negedge clk); linkBusy = 1'b0;
    rdReg(3'd1, got);
    check("R11 idle off-bit", got[7:0], 8'h99);

    // R10 soft reset
    wrReg(3'd0, 32'h0000E101);
    wrReg(3'd2, 32'h78);
    linkRx(32'h12345678);
    wrReg(3'd4, 32'h87654321);
    linkRx(32'h1);
    wrReg(3'd0, 32'h0000E109);
    rdReg(3'd0, got);
    check("R10 control cleared", got, 32'h0);
    rdReg(3'd2, got);
    check("R10 mask cleared", got, 32'h0);
    rdReg(3'd1, got);
    check("R10 status reset", got, 32'h99);
    rdReg(3'd4, got);
    check("R10 rx emptied", got, 32'h0);
    check("R10 tx emptied", txData, 32'h0);
    check("R10 linkEnable", {31'h0, linkEnable}, 32'h0);
    check("R10 irq", {31'h0, irq}, 32'h0);

    finishRun();
  end
endmodule